// File: doc/BRIEF.md
# Configurable Four-Input Logic Element

This block is one fine-grained cell of a programmable gate-array fabric. A 16-bit truth-table mask turns its four data inputs into any Boolean function. A single storage bit sits behind the table. That bit can behave as a D, T, JK or SR flip-flop, or it can be left out of the path. Static configuration inputs choose one of four operating modes: plain logic, one bit of an adder, one bit of an up/down counter, or one bit of a counter with a synchronous clear. The same inputs set the register behaviour, the asynchronous control source and the two output selections.

Neighbouring cells are linked through a dedicated carry line and a dedicated cascade line, so ripple arithmetic and wide AND terms need no general routing. The cell has two outputs, one local and one global. Each output picks either the table result or the register on its own. This lets the table and the register serve unrelated functions at the same time, which is known as register packing. A block-level pair of control lines can clear the register asynchronously. Alternatively, the first control line can load data input 3 into the register asynchronously.

Top module: `lut_le`

## Requirements
- R1: While rst_n is low the register is 0, so any output that selects the register reads 0.
- R2: In mode 0 (plain logic) the table output is lut_mask bit number {d[3],d[2],d[1],d[0]}.
- R3: In mode 1 (adder bit) the table output is lut_mask[i] and carry_out is lut_mask[8+i], where i = {d[1],d[0],carry_in}.
- R4: In modes 0 and 1 the register updates from the table output T according to reg_kind. 0 is D (takes T). 1 is toggle (flips when T=1). 2 is JK with J=T and K=d[3], and J=K=1 flips. 3 is SR with S=T and R=d[3], and R has priority.
- R5: When ena is low the register holds at the clock edge in every mode.
- R6: In mode 2 (up/down counter bit) the next bit is d[0] if d[2]=1 (synchronous load), otherwise q XOR carry_in. The table output equals that next bit. carry_out is carry_in AND q when d[1]=1 (up), and carry_in AND NOT q when d[1]=0 (down).
- R7: In mode 3 (clearable counter bit) the next bit is 0 when d[2]=1, otherwise q XOR carry_in. The table output equals that next bit, and carry_out is carry_in AND q.
- R8: async_sel picks the asynchronous control. 0 is none. 1 means ctl0 high clears the register. 2 means ctl1 high clears it. 3 means ctl0 high copies d[3] into the register. An active control overrides the clock and ena.
- R9: local_out and global_out each show the table output when their select bit is 0 and the register when it is 1. The two selects are independent of each other.
- R10: cascade_out is the table output ANDed with cascade_in.
- R11: In mode 0, carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset of the register |
| lut_mask | input | 16 | Truth-table contents (configuration) |
| op_mode | input | 2 | 0 logic, 1 adder, 2 up/down counter, 3 clearable counter |
| reg_kind | input | 2 | 0 D, 1 T, 2 JK, 3 SR |
| async_sel | input | 2 | Asynchronous control source (R8) |
| local_sel | input | 1 | Local output source: 0 table, 1 register |
| global_sel | input | 1 | Global output source: 0 table, 1 register |
| d | input | 4 | Data inputs |
| carry_in | input | 1 | Carry from the previous cell |
| cascade_in | input | 1 | Cascade from the previous cell, tie high if unused |
| ena | input | 1 | Synchronous clock enable |
| ctl0 | input | 1 | First block control line |
| ctl1 | input | 1 | Second block control line |
| local_out | output | 1 | Local output |
| global_out | output | 1 | Global output |
| carry_out | output | 1 | Carry to the next cell |
| cascade_out | output | 1 | Cascade to the next cell |

## Verification
The assertions rely on a few properties of the inputs. The configuration inputs are meant to stay constant. The control lines ctl0 and ctl1 are clean level signals. Data and control inputs never change at a rising clock edge. The register-hold and synchronous-clear properties therefore accept a control line or an output-select change in the following cycle as a legal exception. The stimulus changes every input one nanosecond after the rising edge and changes the configuration only between test phases. Each phase drives random data, carry, cascade and enable values under one fixed configuration.

// File: rtl/lut_le_pkg.sv
package lut_le_pkg;

    typedef enum logic [1:0] {
        MODE_LOGIC  = 2'd0,
        MODE_ADDER  = 2'd1,
        MODE_UPDOWN = 2'd2,
        MODE_CLRCNT = 2'd3
    } le_mode_t;

    typedef enum logic [1:0] {
        KIND_D  = 2'd0,
        KIND_T  = 2'd1,
        KIND_JK = 2'd2,
        KIND_SR = 2'd3
    } le_kind_t;

    typedef enum logic [1:0] {
        ASYNC_OFF    = 2'd0,
        ASYNC_CLR_C0 = 2'd1,
        ASYNC_CLR_C1 = 2'd2,
        ASYNC_LD_C0  = 2'd3
    } le_async_t;

endpackage

// File: rtl/lut_le_func.sv
module lut_le_func
    import lut_le_pkg::*;
#(
    parameter int LUT_K = 4
) (
    input  le_mode_t               mode,
    input  logic [(1<<LUT_K)-1:0]  mask,
    input  logic [LUT_K-1:0]       d,
    input  logic                   cin,
    input  logic                   q,
    output logic                   table_y,
    output logic                   cout
);
    localparam int MASK_W = 1 << LUT_K;
    localparam int HALF   = MASK_W / 2;

    logic [2:0]       arith_idx;
    logic [LUT_K-1:0] sum_idx;
    logic [LUT_K-1:0] carry_idx;

    always_comb begin
        arith_idx = {d[1], d[0], cin};
        sum_idx   = LUT_K'(arith_idx);
        carry_idx = LUT_K'(arith_idx) | LUT_K'(HALF);
    end

    always_comb begin
        table_y = 1'b0;
        cout    = 1'b0;
        unique case (mode)
            MODE_LOGIC: begin
                table_y = mask[d];
                cout    = 1'b0;
            end
            MODE_ADDER: begin
                table_y = mask[sum_idx];
                cout    = mask[carry_idx];
            end
            MODE_UPDOWN: begin
                table_y = d[2] ? d[0] : (q ^ cin);
                cout    = cin & (d[1] ? q : ~q);
            end
            MODE_CLRCNT: begin
                table_y = d[2] ? 1'b0 : (q ^ cin);
                cout    = cin & q;
            end
            default: begin
                table_y = 1'b0;
                cout    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lut_le_reg.sv
module lut_le_reg
    import lut_le_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ena,
    input  logic     counting,
    input  le_kind_t kind,
    input  logic     table_y,
    input  logic     aux_in,
    input  logic     aclr,
    input  logic     aset,
    output logic     q
);
    logic nxt;

    always_comb begin
        nxt = q;
        if (counting) begin
            nxt = table_y;
        end else begin
            unique case (kind)
                KIND_D:  nxt = table_y;
                KIND_T:  nxt = q ^ table_y;
                KIND_JK: begin
                    unique case ({table_y, aux_in})
                        2'b00:   nxt = q;
                        2'b01:   nxt = 1'b0;
                        2'b10:   nxt = 1'b1;
                        default: nxt = ~q;
                    endcase
                end
                KIND_SR: nxt = aux_in ? 1'b0 : (table_y ? 1'b1 : q);
                default: nxt = q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n or posedge aclr or posedge aset) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (aclr) begin
            q <= 1'b0;
        end else if (aset) begin
            q <= 1'b1;
        end else if (ena) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/lut_le.sv
module lut_le
    import lut_le_pkg::*;
#(
    parameter int LUT_K = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<LUT_K)-1:0] lut_mask,
    input  logic [1:0]            op_mode,
    input  logic [1:0]            reg_kind,
    input  logic [1:0]            async_sel,
    input  logic                  local_sel,
    input  logic                  global_sel,
    input  logic [LUT_K-1:0]      d,
    input  logic                  carry_in,
    input  logic                  cascade_in,
    input  logic                  ena,
    input  logic                  ctl0,
    input  logic                  ctl1,
    output logic                  local_out,
    output logic                  global_out,
    output logic                  carry_out,
    output logic                  cascade_out
);
    le_mode_t  mode;
    le_kind_t  kind;
    le_async_t asel;
    logic      table_y;
    logic      q;
    logic      aclr;
    logic      aset;
    logic      counting;

    always_comb begin
        mode     = le_mode_t'(op_mode);
        kind     = le_kind_t'(reg_kind);
        asel     = le_async_t'(async_sel);
        counting = (mode == MODE_UPDOWN) || (mode == MODE_CLRCNT);
    end

    always_comb begin
        aclr = 1'b0;
        aset = 1'b0;
        unique case (asel)
            ASYNC_OFF:    aclr = 1'b0;
            ASYNC_CLR_C0: aclr = ctl0;
            ASYNC_CLR_C1: aclr = ctl1;
            ASYNC_LD_C0: begin
                aclr = ctl0 & ~d[3];
                aset = ctl0 &  d[3];
            end
            default:      aclr = 1'b0;
        endcase
    end

    lut_le_func #(.LUT_K(LUT_K)) u_func (
        .mode    (mode),
        .mask    (lut_mask),
        .d       (d),
        .cin     (carry_in),
        .q       (q),
        .table_y (table_y),
        .cout    (carry_out)
    );

    lut_le_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ena      (ena),
        .counting (counting),
        .kind     (kind),
        .table_y  (table_y),
        .aux_in   (d[3]),
        .aclr     (aclr),
        .aset     (aset),
        .q        (q)
    );

    always_comb begin
        local_out   = local_sel  ? q : table_y;
        global_out  = global_sel ? q : table_y;
        cascade_out = table_y & cascade_in;
    end

endmodule

// File: rtl/lut_le_chk.sv
module lut_le_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  op_mode,
    input logic [1:0]  async_sel,
    input logic        local_sel,
    input logic        global_sel,
    input logic [3:0]  d,
    input logic        cascade_in,
    input logic        ena,
    input logic        ctl0,
    input logic        ctl1,
    input logic        local_out,
    input logic        global_out,
    input logic        cascade_out
);
    AST_CASCADE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_out |-> cascade_in); // R10

    AST_ENA_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ena && !ctl0 && !ctl1 && local_sel)
        |=> (ctl0 || ctl1 || !local_sel || local_out == $past(local_out))); // R5

    AST_ASYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (((async_sel == 2'd1) && ctl0) || ((async_sel == 2'd2) && ctl1)) && global_sel
        |-> !global_out); // R8

    AST_ASYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((async_sel == 2'd3) && ctl0 && global_sel) |-> (global_out == d[3])); // R8

    AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_mode == 2'd3) && d[2] && ena && !ctl0 && !ctl1 && local_sel)
        |=> (!local_out || ctl0 || ctl1 || !local_sel || op_mode != 2'd3)); // R7

endmodule

bind lut_le lut_le_chk u_lut_le_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_mode     (op_mode),
    .async_sel   (async_sel),
    .local_sel   (local_sel),
    .global_sel  (global_sel),
    .d           (d[3:0]),
    .cascade_in  (cascade_in),
    .ena         (ena),
    .ctl0        (ctl0),
    .ctl1        (ctl1),
    .local_out   (local_out),
    .global_out  (global_out),
    .cascade_out (cascade_out)
);

// File: tb/test_lut_le.sv
module test_lut_le;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] lut_mask;
    logic [1:0]  op_mode, reg_kind, async_sel;
    logic        local_sel, global_sel;
    logic [3:0]  d;
    logic        carry_in, cascade_in, ena, ctl0, ctl1;
    logic        local_out, global_out, carry_out, cascade_out;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string tag      = "R1";
    bit    mq       = 1'b0;

    always #2 clk = ~clk;

    lut_le i_lut_le (
        .clk(clk), .rst_n(rst_n), .lut_mask(lut_mask), .op_mode(op_mode),
        .reg_kind(reg_kind), .async_sel(async_sel), .local_sel(local_sel),
        .global_sel(global_sel), .d(d), .carry_in(carry_in),
        .cascade_in(cascade_in), .ena(ena), .ctl0(ctl0), .ctl1(ctl1),
        .local_out(local_out), .global_out(global_out),
        .carry_out(carry_out), .cascade_out(cascade_out)
    );

    // behavioural reference of the table path for the present inputs
    function automatic bit [1:0] ref_table(bit qv);
        int  i;
        bit  y, c;
        case (op_mode)
            2'd0: begin y = lut_mask[d]; c = 1'b0; end
            2'd1: begin
                i = d[1] * 4 + d[0] * 2 + carry_in;
                y = lut_mask[i];
                c = lut_mask[8 + i];
            end
            2'd2: begin
                y = d[2] ? d[0] : (qv != carry_in);
                c = carry_in && (d[1] ? qv : !qv);
            end
            default: begin
                y = d[2] ? 1'b0 : (qv != carry_in);
                c = carry_in && qv;
            end
        endcase
        return {y, c};
    endfunction

    function automatic bit ref_next(bit qv);
        bit y;
        y = ref_table(qv)[1];
        if (op_mode >= 2'd2) return y;
        case (reg_kind)
            2'd0: return y;
            2'd1: return qv ^ y;
            2'd2: begin
                if (y && d[3]) return !qv;
                if (y) return 1'b1;
                if (d[3]) return 1'b0;
                return qv;
            end
            default: begin
                if (d[3]) return 1'b0;
                if (y) return 1'b1;
                return qv;
            end
        endcase
    endfunction

    function automatic int ref_async();
        // 0 none, 1 clear, 2 set
        if (async_sel == 2'd1 && ctl0) return 1;
        if (async_sel == 2'd2 && ctl1) return 1;
        if (async_sel == 2'd3 && ctl0) return d[3] ? 2 : 1;
        return 0;
    endfunction

    task automatic chk(string rq, logic act, logic exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", rq, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) mq = 1'b0;
        else if (ref_async() == 1) mq = 1'b0;
        else if (ref_async() == 2) mq = 1'b1;
        else if (ena) mq = ref_next(mq);
    end

    always @(negedge clk) begin
        bit [1:0] tc;
        if (!done) begin
            if (!rst_n) mq = 1'b0;
            else if (ref_async() == 1) mq = 1'b0;
            else if (ref_async() == 2) mq = 1'b1;
            tc = ref_table(mq);
            chk(tag, local_out,  local_sel  ? mq : tc[1], "local_out");
            chk(tag, global_out, global_sel ? mq : tc[1], "global_out");
            chk(op_mode == 2'd0 ? "R11" : tag, carry_out, tc[0], "carry_out");
            chk("R10", cascade_out, tc[1] & cascade_in, "cascade_out");
        end
    end

    task automatic phase(string t, logic [1:0] m, logic [1:0] k, logic [1:0] a,
                         logic ls, logic gs, int cycles, int ena_pct, int ctl_pct);
        @(posedge clk); #1;
        tag = t; op_mode = m; reg_kind = k; async_sel = a;
        local_sel = ls; global_sel = gs;
        lut_mask = 16'($urandom);
        for (int c = 0; c < cycles; c++) begin
            d          = 4'($urandom);
            carry_in   = 1'($urandom);
            cascade_in = ($urandom % 4) != 0;
            ena        = ($urandom % 100) < ena_pct;
            ctl0       = ($urandom % 100) < ctl_pct;
            ctl1       = ($urandom % 100) < ctl_pct;
            @(posedge clk); #1;
        end
        ctl0 = 1'b0; ctl1 = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; lut_mask = 16'h6996; op_mode = 2'd0; reg_kind = 2'd0;
        async_sel = 2'd0; local_sel = 1'b1; global_sel = 1'b0; d = 4'h5;
        carry_in = 1'b1; cascade_in = 1'b1; ena = 1'b1; ctl0 = 1'b0; ctl1 = 1'b0;
        tag = "R1";
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        phase("R2",  2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 60, 100, 0);
        phase("R9",  2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 40, 100, 0);
        phase("R3",  2'd1, 2'd0, 2'd0, 1'b0, 1'b1, 80, 100, 0);
        for (int k = 0; k < 4; k++) begin
            phase("R4", 2'd0, 2'(k), 2'd0, 1'b1, 1'b0, 60, 100, 0);
            phase("R4", 2'd1, 2'(k), 2'd0, 1'b0, 1'b1, 40, 100, 0);
        end
        phase("R5",  2'd0, 2'd1, 2'd0, 1'b1, 1'b1, 60, 40, 0);
        phase("R5",  2'd2, 2'd0, 2'd0, 1'b1, 1'b0, 60, 40, 0);
        phase("R6",  2'd2, 2'd0, 2'd0, 1'b1, 1'b0, 120, 90, 0);
        phase("R7",  2'd3, 2'd0, 2'd0, 1'b0, 1'b1, 120, 90, 0);
        for (int a = 1; a < 4; a++) begin
            phase("R8", 2'd0, 2'd1, 2'(a), 1'b1, 1'b1, 80, 80, 25);
            phase("R8", 2'd3, 2'd0, 2'(a), 1'b0, 1'b1, 60, 80, 25);
        end
        // reset mid-run
        @(posedge clk); #1 rst_n = 1'b0; tag = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        phase("R10", 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 40, 100, 0);
        phase("R11", 2'd0, 2'd2, 2'd0, 1'b1, 1'b0, 40, 100, 0);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule